// File: doc/BRIEF.md
# March Memory Self-Test Controller

This controller exercises a synchronous single-port SRAM with march algorithms read from a small, rewritable instruction store. Each instruction describes one march element: which way the address walks, one or two read or write operations per address, the data polarity of each operation, and a data background. When the engine reaches a pause instruction, it stops issuing memory operations for a programmable time. This provides a retention test. The controller issues at most one memory operation per clock at the functional clock rate.

Each read is compared with the value that the element and background imply for that address. Every mismatch produces a diagnostic record that holds the failing address, the word that was read and the word that was expected. Records leave in the order the addresses were visited, through a two-entry queue that a stall input can hold back. At the end of a run the controller reports done and a pass flag. It also keeps a failure count that saturates. Out of reset the store holds the six-element March C− program.

Top module: `mbist_march`

## Requirements
- R1: After reset, busy, done, pass, fail_valid and mem_en are low and fail_count is 0. The store holds March C− in six entries: up w0; up r0,w1; up r1,w0; down r0,w1; down r1,w0; up r0. On a 64-word memory this gives 640 memory operations.
- R2: An instruction word is 11 bits. Bit 10 is valid. Bit 9 selects descending order. Bits 8:7 give the operation count. Bits 6 and 5 are the read flag and data bit of the first operation. Bits 4 and 3 are the read flag and data bit of the second operation. Bits 2:1 select the background. Bit 0 marks a pause.
- R3: An ascending element walks addresses from 0 to the top. A descending element walks from the top to 0.
- R4: Operation count 1 applies the first operation only. Count 2 or 3 applies both operations, in the same address, on consecutive issue cycles. Count 0 skips the element with no memory operation.
- R5: A written or expected word has every bit equal to the operation's data bit XOR an inversion bit. The inversion bit comes from the background:
  - 0 (solid): the inversion bit is 0.
  - 1 (checkerboard): the inversion bit is addr[COL_BITS] XOR addr[0].
  - 2 (row stripes): the inversion bit is addr[COL_BITS].
  - 3 (column stripes): the inversion bit is addr[0].
- R6: Read data is compared one cycle after the read is issued. Each mismatch yields exactly one record carrying the address, the read word and the expected word. Records leave in address-visit order.
- R7: fail_count counts mismatches and saturates at 2^CNT_W−1. When done is high, pass is high exactly when the run had no mismatch.
- R8: A pause entry issues no memory operation. The first operation after the pause issues pause_len+4 cycles after the last operation before it.
- R9: While stall is high, no memory operation issues and a presented record stays unchanged. A record is consumed on a clock edge where fail_valid is high and stall is low.
- R10: Instruction writes are accepted only while busy is low.
- R11: A run ends at an entry with valid=0, or after the last store entry. done then rises once every record has drained, and stays high until the next start. A start clears fail_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when not busy |
| pause_len | input | PAUSE_W | Pause length for pause entries |
| prog_we | input | 1 | Instruction write strobe |
| prog_addr | input | clog2(PROG_DEPTH) | Instruction store index |
| prog_data | input | 11 | Instruction word |
| stall | input | 1 | Diagnostic sink not ready; holds the engine |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished and records drained |
| pass | output | 1 | Finished with no mismatch |
| fail_valid | output | 1 | A diagnostic record is presented |
| fail_addr | output | AW | Failing address |
| fail_data | output | DW | Word read |
| fail_expected | output | DW | Word expected |
| fail_count | output | CNT_W | Saturating mismatch count |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after the read |

## Verification
If the sequencer jumps to the wrong element or loses the address direction, the total operation count changes or the logged address order breaks. Both are visible within the first few operations of a run. If the compare stage is misaligned, spurious or missing records appear on the first read of a fault-free memory. If the queue loses track of its occupancy, records are duplicated, dropped or reordered when the stall pattern holds them back. A wrong background shows up in the memory contents right after a single write element.

// File: rtl/mbist_march.sv
module mbist_march #(
  parameter int AW         = 6,
  parameter int DW         = 8,
  parameter int COL_BITS   = 3,
  parameter int PROG_DEPTH = 8,
  parameter int PAUSE_W    = 16,
  parameter int CNT_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [PAUSE_W-1:0]    pause_len,
  input  logic                  prog_we,
  input  logic [((PROG_DEPTH>1)?$clog2(PROG_DEPTH):1)-1:0] prog_addr,
  input  logic [10:0]           prog_data,
  input  logic                  stall,
  output logic                  busy,
  output logic                  done,
  output logic                  pass,
  output logic                  fail_valid,
  output logic [AW-1:0]         fail_addr,
  output logic [DW-1:0]         fail_data,
  output logic [DW-1:0]         fail_expected,
  output logic [CNT_W-1:0]      fail_count,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata
);
  localparam int PCW = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1;
  localparam int IW  = 11;
  localparam logic [AW-1:0]    ADDR_TOP = {AW{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [PCW-1:0]   PC_LAST  = PCW'(PROG_DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_OPS, S_PAUSE, S_FLUSH, S_DONE} state_t;

  function automatic logic [IW-1:0] boot_entry(input int i);
    case (i)
      0: return {1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0};
      1: return {1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0};
      2: return {1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0};
      3: return {1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0};
      4: return {1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0};
      5: return {1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0};
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a, input logic d,
                                            input logic [1:0] bg);
    logic inv;
    case (bg)
      2'd0:    inv = 1'b0;
      2'd1:    inv = a[COL_BITS] ^ a[0];
      2'd2:    inv = a[COL_BITS];
      default: inv = a[0];
    endcase
    return {DW{d ^ inv}};
  endfunction

  logic [IW-1:0]      prog [PROG_DEPTH];
  state_t             st;
  logic [PCW-1:0]     pc;
  logic [AW-1:0]      addr;
  logic               opi;
  logic [PAUSE_W-1:0] pcnt;
  logic               any_fail;

  logic               rd_pend;
  logic [AW-1:0]      rd_addr;
  logic [DW-1:0]      rd_exp;

  logic [1:0]         qcnt;
  logic [AW-1:0]      q0_addr, q1_addr;
  logic [DW-1:0]      q0_data, q1_data, q0_exp, q1_exp;

  logic [IW-1:0] ins;
  assign ins = prog[pc];

  wire       i_valid = ins[10];
  wire       i_down  = ins[9];
  wire [1:0] i_cnt   = ins[8:7];
  wire       i_rd0   = ins[6];
  wire       i_d0    = ins[5];
  wire       i_rd1   = ins[4];
  wire       i_d1    = ins[3];
  wire [1:0] i_bg    = ins[2:1];
  wire       i_pause = ins[0];

  wire cur_rd     = opi ? i_rd1 : i_rd0;
  wire cur_d      = opi ? i_d1  : i_d0;
  wire last_addr  = i_down ? (addr == '0) : (addr == ADDR_TOP);
  wire last_entry = (pc == PC_LAST);
  wire idle_like  = (st == S_IDLE) || (st == S_DONE);
  wire go         = start && idle_like;

  wire [DW-1:0] cur_pat = pattern(addr, cur_d, i_bg);

  wire room  = (qcnt == 2'd0) || ((qcnt == 2'd1) && !rd_pend);
  wire issue = (st == S_OPS) && !stall && room;

  assign mem_en    = issue;
  assign mem_we    = issue && !cur_rd;
  assign mem_addr  = addr;
  assign mem_wdata = cur_pat;

  assign busy = !idle_like;
  assign done = (st == S_DONE);
  assign pass = done && !any_fail;

  wire cmp_fail = rd_pend && (mem_rdata != rd_exp);
  wire pop      = (qcnt != 2'd0) && !stall;
  wire [1:0] q_after_pop = qcnt - {1'b0, pop};

  assign fail_valid    = (qcnt != 2'd0);
  assign fail_addr     = q0_addr;
  assign fail_data     = q0_data;
  assign fail_expected = q0_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PROG_DEPTH; i++) prog[i] <= boot_entry(i);
    end else if (prog_we && idle_like) begin
      prog[prog_addr] <= prog_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pc   <= '0;
      addr <= '0;
      opi  <= 1'b0;
      pcnt <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            st <= S_FETCH;
            pc <= '0;
          end
        end
        S_FETCH: begin
          if (!i_valid) st <= S_FLUSH;
          else if (i_pause) begin
            pcnt <= pause_len;
            st   <= S_PAUSE;
          end else if (i_cnt == 2'd0) begin
            if (last_entry) st <= S_FLUSH;
            else pc <= pc + 1'b1;
          end else begin
            addr <= i_down ? ADDR_TOP : '0;
            opi  <= 1'b0;
            st   <= S_OPS;
          end
        end
        S_OPS: begin
          if (issue) begin
            if (i_cnt[1] && !opi) opi <= 1'b1;
            else begin
              opi <= 1'b0;
              if (last_addr) begin
                if (last_entry) st <= S_FLUSH;
                else begin
                  pc <= pc + 1'b1;
                  st <= S_FETCH;
                end
              end else begin
                addr <= i_down ? addr - 1'b1 : addr + 1'b1;
              end
            end
          end
        end
        S_PAUSE: begin
          if (!stall) begin
            if (pcnt == '0) begin
              if (last_entry) st <= S_FLUSH;
              else begin
                pc <= pc + 1'b1;
                st <= S_FETCH;
              end
            end else begin
              pcnt <= pcnt - 1'b1;
            end
          end
        end
        S_FLUSH: begin
          if (!rd_pend && qcnt == 2'd0) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_addr <= '0;
      rd_exp  <= '0;
    end else begin
      rd_pend <= issue && cur_rd;
      if (issue && cur_rd) begin
        rd_addr <= addr;
        rd_exp  <= cur_pat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt    <= 2'd0;
      q0_addr <= '0;
      q0_data <= '0;
      q0_exp  <= '0;
      q1_addr <= '0;
      q1_data <= '0;
      q1_exp  <= '0;
    end else begin
      if (pop) begin
        q0_addr <= q1_addr;
        q0_data <= q1_data;
        q0_exp  <= q1_exp;
      end
      if (cmp_fail) begin
        if (q_after_pop == 2'd0) begin
          q0_addr <= rd_addr;
          q0_data <= mem_rdata;
          q0_exp  <= rd_exp;
        end else begin
          q1_addr <= rd_addr;
          q1_data <= mem_rdata;
          q1_exp  <= rd_exp;
        end
      end
      qcnt <= q_after_pop + {1'b0, cmp_fail};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_count <= '0;
      any_fail   <= 1'b0;
    end else if (go) begin
      fail_count <= '0;
      any_fail   <= 1'b0;
    end else if (cmp_fail) begin
      any_fail <= 1'b1;
      if (fail_count != CNT_MAX) fail_count <= fail_count + 1'b1;
    end
  end

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  p_done_drained_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fail_valid);

  p_rec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_valid && stall) |=> (fail_valid && $stable(fail_addr)
                               && $stable(fail_data) && $stable(fail_expected)));

  p_no_op_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !mem_en);

  p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_count == CNT_MAX && !start) |=> (fail_count == CNT_MAX));

  p_pass_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (fail_count == '0));

  p_rec_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid |-> (fail_data != fail_expected));
endmodule

// File: tb/sim_mbist_march.sv
module sim_mbist_march;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pause_len = '0;
  logic        prog_we = 1'b0;
  logic [2:0]  prog_addr = '0;
  logic [10:0] prog_data = '0;
  logic        stall = 1'b0;
  logic        busy, done, pass, fail_valid, mem_en, mem_we;
  logic [5:0]  fail_addr, mem_addr;
  logic [7:0]  fail_data, fail_expected, fail_count, mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #2 clk = ~clk;

  mbist_march u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pause_len(pause_len),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data), .stall(stall),
    .busy(busy), .done(done), .pass(pass), .fail_valid(fail_valid),
    .fail_addr(fail_addr), .fail_data(fail_data), .fail_expected(fail_expected),
    .fail_count(fail_count), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  int tests = 0, fails = 0;
  logic [7:0] mem [64];
  int sa_a = -1, sa_b = -1;
  bit flip_all = 0;
  bit stall_mode = 0;
  int cyc = 0, ops = 0, last_op = -1, max_gap = 0, stall_viol = 0, nrec = 0;
  int log_addr [16];
  bit log_we [16];
  int rec_addr [512];
  int rec_data [512];
  int rec_exp [512];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= (mem[mem_addr] |
                         ((int'(mem_addr) == sa_a || int'(mem_addr) == sa_b) ? 8'h01 : 8'h00))
                        ^ (flip_all ? 8'h01 : 8'h00);
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_en) begin
      if (ops < 16) begin
        log_addr[ops] = int'(mem_addr);
        log_we[ops] = mem_we;
      end
      if (last_op >= 0 && cyc - last_op > max_gap) max_gap = cyc - last_op;
      last_op = cyc;
      ops = ops + 1;
      if (stall) stall_viol = stall_viol + 1;
    end
    if (fail_valid && !stall) begin
      if (nrec < 512) begin
        rec_addr[nrec] = int'(fail_addr);
        rec_data[nrec] = int'(fail_data);
        rec_exp[nrec] = int'(fail_expected);
      end
      nrec = nrec + 1;
    end
  end

  always @(negedge clk) stall <= stall_mode && (cyc % 3 != 0);

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] enc(bit dn, int cnt, bit r0, bit d0, bit r1, bit d1,
                                      int bg, bit p);
    return {1'b1, dn, 2'(cnt), r0, d0, r1, d1, 2'(bg), p};
  endfunction

  task automatic wr(int idx, logic [10:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 3'(idx); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic load_marchc();
    wr(0, enc(0, 1, 0, 0, 0, 0, 0, 0));
    wr(1, enc(0, 2, 1, 0, 0, 1, 0, 0));
    wr(2, enc(0, 2, 1, 1, 0, 0, 0, 0));
    wr(3, enc(1, 2, 1, 0, 0, 1, 0, 0));
    wr(4, enc(1, 2, 1, 1, 0, 0, 0, 0));
    wr(5, enc(0, 1, 1, 0, 0, 0, 0, 0));
    wr(6, 11'd0);
    wr(7, 11'd0);
  endtask

  task automatic launch();
    @(negedge clk);
    ops = 0; last_op = -1; max_gap = 0; nrec = 0; stall_viol = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run();
    launch();
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "pass", int'(pass), 0);
    chk("R1", "fail_valid", int'(fail_valid), 0);
    chk("R1", "mem_en", int'(mem_en), 0);
    chk("R1", "fail_count", int'(fail_count), 0);
  endtask

  task automatic t_boot_program();
    run();
    chk("R1", "boot program ops", ops, 640);
    chk("R1", "boot pass", int'(pass), 1);
    chk("R3", "first op addr", log_addr[0], 0);
    chk("R3", "second op addr", log_addr[1], 1);
    chk("R11", "busy after done", int'(busy), 0);
  endtask

  task automatic t_stuck_bit();
    sa_a = 5;
    run();
    chk("R6", "record count", nrec, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R6", "rec addr", rec_addr[i], 5);
      chk("R6", "rec data", rec_data[i], 1);
      chk("R6", "rec expected", rec_exp[i], 0);
    end
    chk("R7", "fail_count", int'(fail_count), 3);
    chk("R7", "pass low", int'(pass), 0);
    sa_a = -1;
  endtask

  task automatic t_busy_write();
    load_marchc();
    launch();
    repeat (5) @(negedge clk);
    prog_we = 1'b1; prog_addr = 3'd0; prog_data = 11'd0;
    @(negedge clk);
    prog_addr = 3'd1;
    @(negedge clk);
    prog_we = 1'b0;
    while (!done) @(negedge clk);
    chk("R10", "ops with write while busy", ops, 640);
    chk("R11", "count cleared by start", int'(fail_count), 0);
    run();
    chk("R10", "program intact on rerun", ops, 640);
  endtask

  task automatic t_background(int bg, int e1, int e8, int e9);
    wr(0, enc(0, 1, 0, 1, 0, 0, bg, 0));
    wr(1, 11'd0);
    run();
    chk("R5", $sformatf("bg%0d addr1", bg), int'(mem[1]), e1);
    chk("R5", $sformatf("bg%0d addr8", bg), int'(mem[8]), e8);
    chk("R5", $sformatf("bg%0d addr9", bg), int'(mem[9]), e9);
  endtask

  task automatic t_checker_readback();
    wr(0, enc(0, 1, 0, 1, 0, 0, 1, 0));
    wr(1, enc(1, 1, 1, 1, 0, 0, 1, 0));
    wr(2, 11'd0);
    run();
    chk("R5", "checkerboard readback pass", int'(pass), 1);
    chk("R2", "checkerboard ops", ops, 128);
  endtask

  task automatic t_descending_pair();
    wr(0, enc(1, 2, 0, 1, 1, 1, 0, 0));
    wr(1, 11'd0);
    run();
    chk("R3", "desc first addr", log_addr[0], 63);
    chk("R4", "op0 write", int'(log_we[0]), 1);
    chk("R4", "op1 same addr", log_addr[1], 63);
    chk("R4", "op1 read", int'(log_we[1]), 0);
    chk("R3", "desc next addr", log_addr[2], 62);
    chk("R4", "pair ops", ops, 128);
  endtask

  task automatic t_skip_and_end();
    wr(0, enc(0, 0, 0, 1, 0, 1, 0, 0));
    wr(1, enc(0, 1, 0, 0, 0, 0, 0, 0));
    wr(2, 11'd0);
    wr(3, enc(0, 1, 0, 1, 0, 0, 0, 0));
    run();
    chk("R4", "count0 skipped", ops, 64);
    chk("R11", "invalid entry ends run", int'(mem[0]), 0);
  endtask

  task automatic t_last_entry_end();
    for (int i = 0; i < 8; i++) wr(i, enc(0, 1, 0, 0, 0, 0, 0, 0));
    run();
    chk("R11", "store end ends run", ops, 512);
  endtask

  task automatic t_retention();
    pause_len = 16'd20;
    wr(0, enc(0, 1, 0, 1, 0, 0, 0, 0));
    wr(1, enc(0, 0, 0, 0, 0, 0, 0, 1));
    wr(2, enc(0, 1, 1, 1, 0, 0, 0, 0));
    wr(3, 11'd0);
    run();
    chk("R8", "pause gap", max_gap, 24);
    chk("R8", "retention ops", ops, 128);
    chk("R8", "retention pass", int'(pass), 1);
  endtask

  task automatic t_stall_order();
    load_marchc();
    sa_a = 5; sa_b = 6;
    stall_mode = 1;
    run();
    stall_mode = 0;
    chk("R9", "ops during stall", stall_viol, 0);
    chk("R9", "records under stall", nrec, 6);
    chk("R6", "order 0", rec_addr[0], 5);
    chk("R6", "order 1", rec_addr[1], 6);
    chk("R6", "order 2", rec_addr[2], 6);
    chk("R6", "order 3", rec_addr[3], 5);
    chk("R6", "order 4", rec_addr[4], 5);
    chk("R6", "order 5", rec_addr[5], 6);
    chk("R9", "ops under stall", ops, 640);
    sa_a = -1; sa_b = -1;
  endtask

  task automatic t_saturate();
    flip_all = 1;
    run();
    flip_all = 0;
    chk("R7", "saturated count", int'(fail_count), 255);
    chk("R6", "all records", nrec, 320);
    chk("R7", "pass low", int'(pass), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_boot_program();
    t_stuck_bit();
    t_busy_write();
    t_background(0, 255, 255, 255);
    t_background(1, 0, 0, 255);
    t_background(2, 255, 0, 0);
    t_background(3, 0, 255, 0);
    t_checker_readback();
    t_descending_pair();
    t_skip_and_end();
    t_last_entry_end();
    t_retention();
    t_stall_order();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule